// File: doc/BRIEF.md
# Four-Mode Shift Register

This block is a parallel register of `WIDTH` flip-flops, four by default. On each rising clock edge it does one of four things, chosen by a 2-bit mode select: it moves its contents one place toward the most significant end, moves them one place toward the least significant end, takes a full word from the parallel inputs, or keeps what it has. Each shift direction has its own serial input, which fills the bit position left empty by that shift.

The mode select stays 2 bits wide for any data width. Every bit position is one flip-flop fed by a four-way selector that the mode drives. A synchronous active-high reset clears the register and overrides whatever mode is applied. The two end bits are also brought out as serial outputs, taken straight from the flip-flops.

Top module: `usr_reg`

## Requirements
- R1: When `rst` is high at a rising edge, every bit of `q` becomes 0 after that edge, whatever `mode`, `par_in` and the serial inputs are.
- R2: Mode `2'b00` (shift left): after the edge, `q[i]` takes the old `q[i-1]` for i from 1 to WIDTH-1, and `q[0]` takes `ser_in_shl`.
- R3: Mode `2'b01` (shift right): after the edge, `q[i]` takes the old `q[i+1]` for i from 0 to WIDTH-2, and `q[WIDTH-1]` takes `ser_in_shr`.
- R4: Mode `2'b10` (load): after the edge, `q` equals `par_in` as sampled at that edge, with `par_in[i]` going to `q[i]`.
- R5: Mode `2'b11` (hold): `q` keeps its value across the edge, and the parallel and serial inputs have no effect.
- R6: `ser_out_lo` always equals `q[0]` and `ser_out_hi` always equals `q[WIDTH-1]`.
- R7: WIDTH consecutive right shifts fill the register entirely from `ser_in_shr`: the bit applied first ends in `q[0]` and the bit applied last ends in `q[WIDTH-1]`.
- R8: WIDTH consecutive left shifts fill the register entirely from `ser_in_shl`: the bit applied first ends in `q[WIDTH-1]` and the bit applied last ends in `q[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, overrides the mode |
| mode | input | 2 | 00 shift left, 01 shift right, 10 load, 11 hold |
| par_in | input | WIDTH | Word captured in load mode |
| ser_in_shr | input | 1 | Bit that enters the top position on a right shift |
| ser_in_shl | input | 1 | Bit that enters position 0 on a left shift |
| q | output | WIDTH | Register contents |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Top bit of the register |

## Verification
Reset and a mode operation can land on the same edge, and reset has to win. The bench first loads a non-zero word, then raises `rst` while the mode is load with a different non-zero word on `par_in`, and again while the mode is a shift with both serial inputs at 1. In each case it expects `q` to read all zeros after the edge. A long run of random modes and data, compared against a model built from the requirements, also places reset next to every mode, both before and after it.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        USR_SHL  = 2'b00,
        USR_SHR  = 2'b01,
        USR_LOAD = 2'b10,
        USR_HOLD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_bit_sel.sv
module usr_bit_sel
    import usr_pkg::*;
(
    input  usr_mode_e sel,
    input  logic      own,
    input  logic      from_lower,
    input  logic      from_upper,
    input  logic      par,
    output logic      nxt
);

    // Four-way selector in front of one flip-flop.
    always_comb begin
        unique case (sel)
            USR_SHL:  nxt = from_lower;
            USR_SHR:  nxt = from_upper;
            USR_LOAD: nxt = par;
            default:  nxt = own;
        endcase
    end

endmodule

// File: rtl/usr_reg.sv
module usr_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in_shr,
    input  logic             ser_in_shl,
    output logic [WIDTH-1:0] q,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } usr_state_t;

    usr_state_t       st_d, st_q;
    logic [WIDTH-1:0] sel_d;
    usr_mode_e        mode_e;

    assign mode_e = usr_mode_e'(mode);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lo_src, hi_src;
        if (i == 0) begin : g_lo_edge
            assign lo_src = ser_in_shl;
        end else begin : g_lo_mid
            assign lo_src = st_q.bits[i-1];
        end
        if (i == TOP) begin : g_hi_edge
            assign hi_src = ser_in_shr;
        end else begin : g_hi_mid
            assign hi_src = st_q.bits[i+1];
        end
        usr_bit_sel u_sel (
            .sel        (mode_e),
            .own        (st_q.bits[i]),
            .from_lower (lo_src),
            .from_upper (hi_src),
            .par        (par_in[i]),
            .nxt        (sel_d[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else begin
            st_d.bits = sel_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q          = st_q.bits;
    assign ser_out_lo = st_q.bits[0];
    assign ser_out_hi = st_q.bits[TOP];

    // R1: reset wins over any mode
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2: left shift
    a_r2_shift_left: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == {$past(q[TOP-1:0]), $past(ser_in_shl)}));

    // R3: right shift
    a_r3_shift_right: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q == {$past(ser_in_shr), $past(q[TOP:1])}));

    // R4: parallel load
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == $past(par_in)));

    // R5: hold
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> $stable(q));

endmodule

// File: tb/usr_reg_bench.sv
module usr_reg_bench;

    localparam int WIDTH   = 4;
    localparam time CLK_PER = 10ns;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       mode;
    logic [WIDTH-1:0] par_in;
    logic             ser_in_shr, ser_in_shl;
    logic [WIDTH-1:0] q;
    logic             ser_out_lo, ser_out_hi;

    int n_vec  = 0;
    int n_miss = 0;
    logic [WIDTH-1:0] model = '0;

    always #(CLK_PER/2) clk = ~clk;

    usr_reg #(.WIDTH(WIDTH)) u_usr_reg (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .par_in     (par_in),
        .ser_in_shr (ser_in_shr),
        .ser_in_shl (ser_in_shl),
        .q          (q),
        .ser_out_lo (ser_out_lo),
        .ser_out_hi (ser_out_hi)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, clock once, update model, sample 1ns later.
    task automatic step(input logic r, input logic [1:0] m,
                        input logic [WIDTH-1:0] d, input logic sr, input logic sl);
        @(negedge clk);
        rst = r; mode = m; par_in = d; ser_in_shr = sr; ser_in_shl = sl;
        @(posedge clk);
        if (r)              model = '0;
        else if (m == 2'b00) model = {model[WIDTH-2:0], sl};
        else if (m == 2'b01) model = {sr, model[WIDTH-1:1]};
        else if (m == 2'b10) model = d;
        #1;
    endtask

    task automatic t_reset;
        step(1'b1, 2'b10, 4'b1111, 1'b1, 1'b1);
        check("R1 reset", q, '0);
    endtask

    task automatic t_load;
        step(1'b0, 2'b10, 4'b1011, 1'b0, 1'b0);
        check("R4 load 1011", q, 4'b1011);
        step(1'b0, 2'b10, 4'b0110, 1'b1, 1'b1);
        check("R4 load 0110", q, 4'b0110);
    endtask

    task automatic t_shift_left;
        step(1'b0, 2'b10, 4'b1001, 1'b0, 1'b0);
        step(1'b0, 2'b00, 4'b0000, 1'b0, 1'b1);
        check("R2 shl in 1", q, 4'b0011);
        step(1'b0, 2'b00, 4'b1111, 1'b1, 1'b0);
        check("R2 shl in 0", q, 4'b0110);
    endtask

    task automatic t_shift_right;
        step(1'b0, 2'b10, 4'b1001, 1'b0, 1'b0);
        step(1'b0, 2'b01, 4'b0000, 1'b1, 1'b0);
        check("R3 shr in 1", q, 4'b1100);
        step(1'b0, 2'b01, 4'b1111, 1'b0, 1'b1);
        check("R3 shr in 0", q, 4'b0110);
    endtask

    task automatic t_hold;
        step(1'b0, 2'b10, 4'b1010, 1'b0, 1'b0);
        step(1'b0, 2'b11, 4'b0101, 1'b1, 1'b1);
        check("R5 hold ignores inputs", q, 4'b1010);
        step(1'b0, 2'b11, 4'b1111, 1'b0, 1'b0);
        check("R5 hold second cycle", q, 4'b1010);
    endtask

    task automatic t_serial_outs;
        step(1'b0, 2'b10, 4'b1000, 1'b0, 1'b0);
        check("R6 ser outs 1000", {ser_out_hi, ser_out_lo, 2'b00}, 4'b1000);
        step(1'b0, 2'b10, 4'b0001, 1'b0, 1'b0);
        check("R6 ser outs 0001", {ser_out_hi, ser_out_lo, 2'b00}, 4'b0100);
    endtask

    task automatic t_fill_right;
        logic [3:0] pat = 4'b1101;   // applied pat[0] first
        step(1'b0, 2'b10, 4'b0010, 1'b0, 1'b0);
        for (int k = 0; k < WIDTH; k++) step(1'b0, 2'b01, 4'b1111, pat[k], ~pat[k]);
        check("R7 right fill", q, pat);
    endtask

    task automatic t_fill_left;
        logic [3:0] pat = 4'b1101;   // applied pat[3] first
        step(1'b0, 2'b10, 4'b0010, 1'b0, 1'b0);
        for (int k = WIDTH-1; k >= 0; k--) step(1'b0, 2'b00, 4'b1111, ~pat[k], pat[k]);
        check("R8 left fill", q, pat);
    endtask

    task automatic t_reset_collision;
        step(1'b0, 2'b10, 4'b1111, 1'b0, 1'b0);
        step(1'b1, 2'b10, 4'b0110, 1'b1, 1'b1);
        check("R1 reset over load", q, '0);
        step(1'b0, 2'b10, 4'b1001, 1'b0, 1'b0);
        step(1'b1, 2'b00, 4'b1111, 1'b1, 1'b1);
        check("R1 reset over shift", q, '0);
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic r = (($urandom % 16) == 0);
            step(r, 2'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
            check("R1-model random", q, model);
            check("R6 random lo", {3'b000, ser_out_lo}, {3'b000, model[0]});
        end
    endtask

    initial begin
        rst = 1'b1; mode = 2'b11; par_in = '0; ser_in_shr = 1'b0; ser_in_shl = 1'b0;
        t_reset();
        t_load();
        t_shift_left();
        t_shift_right();
        t_hold();
        t_serial_outs();
        t_fill_right();
        t_fill_left();
        t_reset_collision();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(CLK_PER * 20000);
        n_miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule